// File: doc/BRIEF.md
# Asymmetry-aware coherence directory controller

This block is the directory for a group of cores joined by a switched interconnect. For each tracked line it keeps a coherence state, an owning core, a bit vector of the cores that hold a copy, and a flag that marks the line as asymmetric. One core at a time is the primary core. A configuration port names it, and software may change it while the system runs. When the primary holds a line and a secondary core is granted a copy, the line becomes asymmetric. From then on, a write by the primary moves the secondary copies to a volatile permission and does not invalidate them, so the primary never waits for acknowledgements. A write by a secondary pushes an update to the primary and never removes the primary's copy.

Each core has a request port (read, write, invalidate-acknowledge) and receives a response code and snoop messages. The directory accepts one request per cycle. The lowest-numbered requesting core wins, and every message appears on the cycle after acceptance. Lines that the primary does not hold keep to ordinary owned/exclusive/shared handling: symmetric writes invalidate the other holders, and the write grant is held back until the last acknowledgement arrives.

Top module: `dir_ctrl`

## Requirements
- R1: After reset no response or snoop is valid, and core 0 is the primary core.
- R2: At most one request is accepted per cycle, and it is the one from the lowest-numbered requesting core (req_ready one-hot). Its response and snoops are valid for exactly the following cycle. Request op codes are read=0, write=1, acknowledge=2.
- R3: A read of an uncached line returns exclusive (response code 1). A read of a line held exclusively or modified by another core returns shared (code 0) and sends that owner a downgrade snoop (snoop code 1).
- R4: A write to a symmetric line sends an invalidate snoop (code 0) to every other holder. The write grant (code 2) is sent immediately if there are no other holders, and otherwise on the cycle after the last acknowledgement. An acknowledgement to a line with none outstanding has no effect.
- R5: A read or write to a line that still waits for acknowledgements is refused with code 5 and changes nothing.
- R6: A grant to a secondary core while the primary holds the line returns asymmetric-shared (code 3) and marks the line asymmetric.
- R7: A write by the primary to an asymmetric line returns the write grant (code 2) on the next cycle and sends a volatile snoop (code 2) to every other holder, with no invalidate to any core.
- R8: A read by a secondary of an asymmetric line made volatile returns code 4 (served by the primary) and sends no snoop.
- R9: A write by a secondary to an asymmetric line sends an update snoop (code 3) to the primary and invalidates only the other secondaries. The primary never receives an invalidate. Write-through done (code 6) follows when the acknowledgements are complete.
- R10: Writing a different core number to the primary register clears the asymmetric and volatile marks of every line, so the next write to such a line is handled symmetrically.
- R11: A line shared only among secondary cores is never marked asymmetric: its read grants return code 0, not 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the primary-core register |
| cfg_primary | input | CW | Core number to make primary |
| req_valid | input | N | Request present, one bit per core |
| req_op | input | 2*N | Request op per core (read 0, write 1, acknowledge 2) |
| req_line | input | LW*N | Line index per core |
| req_ready | output | N | One-hot acceptance of this cycle's request |
| rsp_valid | output | N | Response valid, one bit per core |
| rsp_code | output | 3*N | Response code per core |
| snp_valid | output | N | Snoop valid, one bit per core |
| snp_code | output | 2*N | Snoop code per core (invalidate 0, downgrade 1, volatile 2, update 3) |
| snp_line | output | LW | Line the current snoops refer to |

## Verification
The bench builds the controller with four cores and four lines, so every core can take each role. The primary is swept over all four cores, and each choice reruns the same scripted traces with the secondaries rotated relative to it. This covers symmetric sharing among secondaries, the asymmetric sharing, volatile and write-through paths, the refusal of requests while acknowledgements are pending, simultaneous requests for arbitration, and a primary change that has to clear asymmetric lines. The expected response and snoop vectors are derived from the core numbers in each iteration.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic [1:0] {
        OP_RD  = 2'd0,
        OP_WR  = 2'd1,
        OP_ACK = 2'd2,
        OP_RSV = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        RS_SHR = 3'd0,
        RS_EXC = 3'd1,
        RS_MOD = 3'd2,
        RS_ASH = 3'd3,
        RS_VOL = 3'd4,
        RS_NAK = 3'd5,
        RS_WTD = 3'd6,
        RS_RSV = 3'd7
    } rsp_e;

    typedef enum logic [1:0] {
        SN_INV = 2'd0,
        SN_DWN = 2'd1,
        SN_VOL = 2'd2,
        SN_UPD = 2'd3
    } snp_e;

    typedef enum logic [2:0] {
        LS_I = 3'd0,
        LS_S = 3'd1,
        LS_E = 3'd2,
        LS_M = 3'd3,
        LS_O = 3'd4
    } lstate_e;

    function automatic logic holds_excl(lstate_e s);
        return (s == LS_E) || (s == LS_M);
    endfunction

endpackage

// File: rtl/dir_arbiter.sv
module dir_arbiter #(
    parameter int N  = 4,
    parameter int CW = 2
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [CW-1:0] idx,
    output logic          any
);
    for (genvar i = 0; i < N; i++) begin : g_pri
        if (i == 0) begin : g_first
            assign gnt[i] = req[i];
        end else begin : g_rest
            assign gnt[i] = req[i] & ~(|req[i-1:0]);
        end
    end

    assign any = |req;

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (gnt[i]) idx = CW'(i);
        end
    end
endmodule

// File: rtl/dir_line_fsm.sv
module dir_line_fsm
    import dir_pkg::*;
#(
    parameter int N  = 4,
    parameter int CW = 2
) (
    input  lstate_e          cur_st,
    input  logic [CW-1:0]    cur_own,
    input  logic [N-1:0]     cur_shr,
    input  logic             cur_asym,
    input  logic             cur_vol,
    input  logic [CW:0]      cur_pend,
    input  logic [CW-1:0]    cur_wait,
    input  rsp_e             cur_wcode,
    input  logic [CW-1:0]    rq_core,
    input  op_e              rq_op,
    input  logic [CW-1:0]    prim,
    output lstate_e          nx_st,
    output logic [CW-1:0]    nx_own,
    output logic [N-1:0]     nx_shr,
    output logic             nx_asym,
    output logic             nx_vol,
    output logic [CW:0]      nx_pend,
    output logic [CW-1:0]    nx_wait,
    output rsp_e             nx_wcode,
    output logic             rsp_en,
    output rsp_e             rsp_code,
    output logic [CW-1:0]    rsp_core,
    output logic [N-1:0]     snp_en,
    output logic [2*N-1:0]   snp_codes
);
    logic [N-1:0] me, pm, others, sec_others;
    logic         is_prim;
    logic [CW:0]  cnt;

    assign me         = N'(1) << rq_core;
    assign pm         = N'(1) << prim;
    assign is_prim    = (rq_core == prim);
    assign others     = cur_shr & ~me;
    assign sec_others = others & ~pm;

    always_comb begin
        nx_st     = cur_st;
        nx_own    = cur_own;
        nx_shr    = cur_shr;
        nx_asym   = cur_asym;
        nx_vol    = cur_vol;
        nx_pend   = cur_pend;
        nx_wait   = cur_wait;
        nx_wcode  = cur_wcode;
        rsp_en    = 1'b0;
        rsp_code  = RS_SHR;
        rsp_core  = rq_core;
        snp_en    = '0;
        snp_codes = '0;
        cnt       = '0;

        case (rq_op)
            OP_ACK: begin
                if (cur_pend != '0) begin
                    nx_pend = cur_pend - (CW+1)'(1);
                    if (cur_pend == (CW+1)'(1)) begin
                        rsp_en   = 1'b1;
                        rsp_code = cur_wcode;
                        rsp_core = cur_wait;
                    end
                end
            end
            OP_RD: begin
                rsp_en = 1'b1;
                if (cur_pend != '0) begin
                    rsp_code = RS_NAK;
                end else if (cur_asym && cur_vol && !is_prim) begin
                    rsp_code = RS_VOL;
                end else if (cur_st == LS_I) begin
                    nx_st    = LS_E;
                    nx_own   = rq_core;
                    nx_shr   = me;
                    rsp_code = RS_EXC;
                end else if (holds_excl(cur_st) && cur_own == rq_core) begin
                    rsp_code = (cur_st == LS_M) ? RS_MOD : RS_EXC;
                end else begin
                    nx_shr = cur_shr | me;
                    if (holds_excl(cur_st)) begin
                        snp_en[cur_own]             = 1'b1;
                        snp_codes[2*cur_own +: 2]   = SN_DWN;
                        nx_st = (cur_st == LS_E) ? LS_S : LS_O;
                    end
                    if (cur_shr[prim] && !is_prim) begin
                        nx_asym  = 1'b1;
                        rsp_code = RS_ASH;
                    end else begin
                        rsp_code = RS_SHR;
                    end
                end
            end
            OP_WR: begin
                if (cur_pend != '0) begin
                    rsp_en   = 1'b1;
                    rsp_code = RS_NAK;
                end else if (cur_st == LS_I) begin
                    nx_st    = LS_M;
                    nx_own   = rq_core;
                    nx_shr   = me;
                    rsp_en   = 1'b1;
                    rsp_code = RS_MOD;
                end else if (cur_asym && is_prim) begin
                    snp_en = others;
                    for (int i = 0; i < N; i++) begin
                        if (others[i]) snp_codes[2*i +: 2] = SN_VOL;
                    end
                    nx_vol   = 1'b1;
                    nx_st    = LS_M;
                    nx_own   = rq_core;
                    rsp_en   = 1'b1;
                    rsp_code = RS_MOD;
                end else if (cur_asym) begin
                    snp_en = sec_others | pm;
                    snp_codes[2*prim +: 2] = SN_UPD;
                    nx_shr = me | pm;
                    nx_st  = LS_O;
                    nx_own = prim;
                    cnt    = (CW+1)'($countones(sec_others));
                    if (cnt == '0) begin
                        rsp_en   = 1'b1;
                        rsp_code = RS_WTD;
                    end else begin
                        nx_pend  = cnt;
                        nx_wait  = rq_core;
                        nx_wcode = RS_WTD;
                    end
                end else begin
                    snp_en = others;
                    nx_st  = LS_M;
                    nx_own = rq_core;
                    nx_shr = me;
                    cnt    = (CW+1)'($countones(others));
                    if (cnt == '0) begin
                        rsp_en   = 1'b1;
                        rsp_code = RS_MOD;
                    end else begin
                        nx_pend  = cnt;
                        nx_wait  = rq_core;
                        nx_wcode = RS_MOD;
                    end
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
    import dir_pkg::*;
#(
    parameter int N     = 4,
    parameter int LINES = 4,
    localparam int CW   = (N > 1) ? $clog2(N) : 1,
    localparam int LW   = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CW-1:0]     cfg_primary,
    input  logic [N-1:0]      req_valid,
    input  logic [2*N-1:0]    req_op,
    input  logic [LW*N-1:0]   req_line,
    output logic [N-1:0]      req_ready,
    output logic [N-1:0]      rsp_valid,
    output logic [3*N-1:0]    rsp_code,
    output logic [N-1:0]      snp_valid,
    output logic [2*N-1:0]    snp_code,
    output logic [LW-1:0]     snp_line
);
    lstate_e       st_q   [LINES];
    logic [CW-1:0] own_q  [LINES];
    logic [N-1:0]  shr_q  [LINES];
    logic          asym_q [LINES];
    logic          vol_q  [LINES];
    logic [CW:0]   pend_q [LINES];
    logic [CW-1:0] wait_q [LINES];
    rsp_e          wcd_q  [LINES];
    logic [CW-1:0] prim_q;

    logic [CW-1:0] gidx;
    logic          gany;
    op_e           sel_op;
    logic [LW-1:0] sel_line;

    dir_arbiter #(.N(N), .CW(CW)) u_arb (
        .req (req_valid),
        .gnt (req_ready),
        .idx (gidx),
        .any (gany)
    );

    assign sel_op   = op_e'(req_op[2*gidx +: 2]);
    assign sel_line = req_line[LW*gidx +: LW];

    lstate_e       nx_st;
    logic [CW-1:0] nx_own, nx_wait, f_core;
    logic [N-1:0]  nx_shr, f_snp_en;
    logic          nx_asym, nx_vol, f_en;
    logic [CW:0]   nx_pend;
    rsp_e          nx_wcode, f_code;
    logic [2*N-1:0] f_snp_codes;

    dir_line_fsm #(.N(N), .CW(CW)) u_fsm (
        .cur_st    (st_q[sel_line]),
        .cur_own   (own_q[sel_line]),
        .cur_shr   (shr_q[sel_line]),
        .cur_asym  (asym_q[sel_line]),
        .cur_vol   (vol_q[sel_line]),
        .cur_pend  (pend_q[sel_line]),
        .cur_wait  (wait_q[sel_line]),
        .cur_wcode (wcd_q[sel_line]),
        .rq_core   (gidx),
        .rq_op     (sel_op),
        .prim      (prim_q),
        .nx_st     (nx_st),
        .nx_own    (nx_own),
        .nx_shr    (nx_shr),
        .nx_asym   (nx_asym),
        .nx_vol    (nx_vol),
        .nx_pend   (nx_pend),
        .nx_wait   (nx_wait),
        .nx_wcode  (nx_wcode),
        .rsp_en    (f_en),
        .rsp_code  (f_code),
        .rsp_core  (f_core),
        .snp_en    (f_snp_en),
        .snp_codes (f_snp_codes)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) begin
                st_q[i]   <= LS_I;
                own_q[i]  <= '0;
                shr_q[i]  <= '0;
                asym_q[i] <= 1'b0;
                vol_q[i]  <= 1'b0;
                pend_q[i] <= '0;
                wait_q[i] <= '0;
                wcd_q[i]  <= RS_SHR;
            end
            prim_q    <= '0;
            rsp_valid <= '0;
            rsp_code  <= '0;
            snp_valid <= '0;
            snp_code  <= '0;
            snp_line  <= '0;
        end else begin
            rsp_valid <= '0;
            rsp_code  <= '0;
            snp_valid <= '0;
            snp_code  <= '0;
            snp_line  <= sel_line;
            if (gany) begin
                st_q[sel_line]   <= nx_st;
                own_q[sel_line]  <= nx_own;
                shr_q[sel_line]  <= nx_shr;
                asym_q[sel_line] <= nx_asym;
                vol_q[sel_line]  <= nx_vol;
                pend_q[sel_line] <= nx_pend;
                wait_q[sel_line] <= nx_wait;
                wcd_q[sel_line]  <= nx_wcode;
                if (f_en) begin
                    rsp_valid[f_core]          <= 1'b1;
                    rsp_code[3*f_core +: 3]    <= f_code;
                end
                snp_valid <= f_snp_en;
                snp_code  <= f_snp_codes;
            end
            if (cfg_we) begin
                prim_q <= cfg_primary;
                if (cfg_primary != prim_q) begin
                    for (int i = 0; i < LINES; i++) begin
                        asym_q[i] <= 1'b0;
                        vol_q[i]  <= 1'b0;
                    end
                end
            end
        end
    end

    // ---------------- checks ----------------
    logic [CW-1:0] chk_core_q, chk_prim_q;
    logic [N-1:0]  inv_mask;

    always_ff @(posedge clk) begin
        chk_core_q <= gidx;
        chk_prim_q <= prim_q;
    end

    for (genvar i = 0; i < N; i++) begin : g_inv
        assign inv_mask[i] = snp_valid[i] && (snp_code[2*i +: 2] == SN_INV);
    end

    // R2
    one_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_ready) && ((req_valid != '0) == (req_ready != '0)));

    // R5
    pend_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (gany && sel_op != OP_ACK && pend_q[sel_line] != '0)
        |=> (rsp_valid[chk_core_q] && rsp_code[3*chk_core_q +: 3] == RS_NAK && snp_valid == '0));

    // R7
    prim_nowait_chk: assert property (@(posedge clk) disable iff (rst)
        (gany && sel_op == OP_WR && asym_q[sel_line] && gidx == prim_q
         && pend_q[sel_line] == '0 && st_q[sel_line] != LS_I && !cfg_we)
        |=> (rsp_valid[chk_core_q] && rsp_code[3*chk_core_q +: 3] == RS_MOD && inv_mask == '0));

    // R9
    keep_primary_chk: assert property (@(posedge clk) disable iff (rst)
        (gany && sel_op == OP_WR && asym_q[sel_line] && gidx != prim_q
         && pend_q[sel_line] == '0)
        |=> (!inv_mask[chk_prim_q] && snp_valid[chk_prim_q]
             && snp_code[2*chk_prim_q +: 2] == SN_UPD));

    // R2
    rsp_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rsp_valid));
endmodule

// File: tb/tb_dir_ctrl.sv
module tb_dir_ctrl;
    localparam int N     = 4;
    localparam int LINES = 4;
    localparam int CW    = 2;
    localparam int LW    = 2;

    localparam int RD = 0, WR = 1, AK = 2;
    localparam int C_SHR = 0, C_EXC = 1, C_MOD = 2, C_ASH = 3, C_VOL = 4, C_NAK = 5, C_WTD = 6;
    localparam int S_INV = 0, S_DWN = 1, S_VOL = 2, S_UPD = 3;

    logic              clk = 1'b0;
    logic              rst;
    logic              cfg_we;
    logic [CW-1:0]     cfg_primary;
    logic [N-1:0]      req_valid;
    logic [2*N-1:0]    req_op;
    logic [LW*N-1:0]   req_line;
    logic [N-1:0]      req_ready;
    logic [N-1:0]      rsp_valid;
    logic [3*N-1:0]    rsp_code;
    logic [N-1:0]      snp_valid;
    logic [2*N-1:0]    snp_code;
    logic [LW-1:0]     snp_line;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    dir_ctrl #(.N(N), .LINES(LINES)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_primary(cfg_primary),
        .req_valid(req_valid), .req_op(req_op), .req_line(req_line),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .snp_valid(snp_valid), .snp_code(snp_code), .snp_line(snp_line)
    );

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic exp_rsp(string tag, int c, int code);
        chk(rsp_valid == (N'(1) << c), tag, "rsp_valid", int'(rsp_valid), 1 << c);
        chk(int'(rsp_code[3*c +: 3]) == code, tag, "rsp_code", int'(rsp_code[3*c +: 3]), code);
    endtask

    task automatic exp_no_rsp(string tag);
        chk(rsp_valid == '0, tag, "rsp_valid idle", int'(rsp_valid), 0);
    endtask

    task automatic exp_snp(string tag, int mask, int code);
        chk(int'(snp_valid) == mask, tag, "snp_valid", int'(snp_valid), mask);
        for (int i = 0; i < N; i++) begin
            if (mask[i]) chk(int'(snp_code[2*i +: 2]) == code, tag, "snp_code",
                             int'(snp_code[2*i +: 2]), code);
        end
    endtask

    task automatic issue(int c, int op, int ln);
        @(negedge clk);
        req_valid = '0;
        req_valid[c] = 1'b1;
        req_op[2*c +: 2] = 2'(op);
        req_line[LW*c +: LW] = LW'(ln);
        @(negedge clk);
        req_valid = '0;
    endtask

    task automatic set_primary(int p);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_primary = CW'(p);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cfg_we = 1'b0;
        req_valid = '0;
        req_op = '0;
        req_line = '0;
        cfg_primary = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rsp_valid == '0, "R1", "rsp after reset", int'(rsp_valid), 0);
        chk(snp_valid == '0, "R1", "snp after reset", int'(snp_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        cfg_we = 1'b0;
        req_valid = '0;
        req_op = '0;
        req_line = '0;
        cfg_primary = '0;

        // R1: primary defaults to core 0
        do_reset();
        issue(0, RD, 3);
        exp_rsp("R1", 0, C_EXC);
        issue(1, RD, 3);
        exp_rsp("R1", 1, C_ASH);

        for (int p = 0; p < N; p++) begin
            int s1, s2, w, l;
            s1 = (p + 1) % N;
            s2 = (p + 2) % N;
            do_reset();
            set_primary(p);

            // line 0: secondaries only, symmetric path
            issue(s1, RD, 0);
            exp_rsp("R3", s1, C_EXC);
            exp_snp("R3", 0, 0);
            issue(s2, RD, 0);
            exp_rsp("R11", s2, C_SHR);
            exp_snp("R3", 1 << s1, S_DWN);
            issue(s2, WR, 0);
            exp_no_rsp("R4");
            exp_snp("R4", 1 << s1, S_INV);
            issue(s1, RD, 0);
            exp_rsp("R5", s1, C_NAK);
            exp_snp("R5", 0, 0);
            issue(s1, AK, 0);
            exp_rsp("R4", s2, C_MOD);
            exp_snp("R4", 0, 0);

            // line 2: simultaneous requests
            w = (s1 < s2) ? s1 : s2;
            l = (s1 < s2) ? s2 : s1;
            @(negedge clk);
            req_valid = '0;
            req_valid[s1] = 1'b1;
            req_valid[s2] = 1'b1;
            req_op[2*s1 +: 2] = 2'(RD);
            req_op[2*s2 +: 2] = 2'(RD);
            req_line[LW*s1 +: LW] = LW'(2);
            req_line[LW*s2 +: LW] = LW'(2);
            #1;
            chk(req_ready == (N'(1) << w), "R2", "req_ready", int'(req_ready), 1 << w);
            @(negedge clk);
            req_valid = '0;
            exp_rsp("R2", w, C_EXC);
            issue(l, RD, 2);
            exp_rsp("R11", l, C_SHR);
            exp_snp("R3", 1 << w, S_DWN);
            issue(s2, AK, 2);
            exp_no_rsp("R4");
            exp_snp("R4", 0, 0);
            issue(p, WR, 2);
            exp_no_rsp("R4");
            exp_snp("R4", (1 << s1) | (1 << s2), S_INV);
            issue(s1, AK, 2);
            exp_no_rsp("R4");
            issue(s2, AK, 2);
            exp_rsp("R4", p, C_MOD);

            // line 1: asymmetric path
            issue(p, RD, 1);
            exp_rsp("R3", p, C_EXC);
            issue(s1, RD, 1);
            exp_rsp("R6", s1, C_ASH);
            exp_snp("R6", 1 << p, S_DWN);
            issue(s2, RD, 1);
            exp_rsp("R6", s2, C_ASH);
            exp_snp("R6", 0, 0);
            issue(p, WR, 1);
            exp_rsp("R7", p, C_MOD);
            exp_snp("R7", (1 << s1) | (1 << s2), S_VOL);
            issue(s1, RD, 1);
            exp_rsp("R8", s1, C_VOL);
            exp_snp("R8", 0, 0);
            issue(s1, WR, 1);
            exp_no_rsp("R9");
            chk(int'(snp_valid) == ((1 << s2) | (1 << p)), "R9", "snp_valid",
                int'(snp_valid), (1 << s2) | (1 << p));
            chk(int'(snp_code[2*p +: 2]) == S_UPD, "R9", "primary snoop",
                int'(snp_code[2*p +: 2]), S_UPD);
            chk(int'(snp_code[2*s2 +: 2]) == S_INV, "R9", "secondary snoop",
                int'(snp_code[2*s2 +: 2]), S_INV);
            issue(s2, AK, 1);
            exp_rsp("R9", s1, C_WTD);

            // primary change clears the asymmetric mark
            set_primary(s1);
            issue(s1, WR, 1);
            exp_no_rsp("R10");
            exp_snp("R10", 1 << p, S_INV);
            issue(p, AK, 1);
            exp_rsp("R10", s1, C_MOD);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule